// File: doc/BRIEF.md
# SPI Data Line Timing Stage

This block sits between the four SPI data pads and the shift engine and adjusts when each data line is seen. Every incoming line can be passed straight through, or sampled on the rising edge of the module clock, on its falling edge, or on module-clock edges marked by a serial-clock enable strobe. A sampled line then goes through a short shift chain that adds one to four module-clock cycles of delay. The four outgoing lines can each be retimed by half a cycle onto the falling edge of the module clock.

A swap control reverses the order of the four incoming lines before any sampling, so a board that wires the quad lines in reverse order can still be used. All settings are captured into internal registers only while the idle input is high, so a transfer in progress never sees its line timing change.

Top module: `spi_line_timing`

## Requirements
- R1: With the swap setting at 1, lane i is fed from pad line 3-i (0 from 3, 1 from 2, 2 from 1, 3 from 0); with it at 0, lane i is fed from pad line i.
- R2: An input lane with mode code 0 passes its pad value to the core in the same cycle, whatever its count field holds.
- R3: An input lane with mode code 1 outputs the value its pad had at a rising clock edge, delayed by count+1 rising edges.
- R4: An input lane with mode code 2 captures its pad on the falling edge; a pad change made after a falling edge reaches the core one cycle later than under mode code 1 (count+2 edges).
- R5: An input lane with mode code 3 takes a new pad sample only on rising edges where the serial-clock strobe is high, holds it otherwise, and outputs that sample after count+1 further rising edges.
- R6: The 2-bit count field of each input lane gives a delay of count+1 cycles: 0 gives 1, 1 gives 2, 2 gives 3, 3 gives 4.
- R7: An output line with mode bit 0 passes the core value to the pad in the same cycle; with mode bit 1 the pad shows the core value captured at the latest falling clock edge.
- R8: Settings are taken on a rising edge only when idle is high; while idle is low the previously taken settings remain in force.
- R9: Reset clears all taken settings (mode 0 on every input lane, swap off, mode bit 0 on every output) and all sampling registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous reset, active low |
| idle | input | 1 | High when no transfer runs; settings are taken only then |
| sck_en | input | 1 | Serial-clock strobe for mode 3 sampling |
| cfg_swap | input | 1 | Reverse the order of the incoming lines |
| cfg_in_mode | input | 8 | Sampling mode per input lane, 2 bits each, lane i at bits 2i+1:2i |
| cfg_in_cnt | input | 8 | Delay count per input lane, 2 bits each, lane i at bits 2i+1:2i |
| cfg_out_mode | input | 4 | Falling-edge retime enable per output line |
| pad_din | input | 4 | Raw data lines from the pads |
| core_din | output | 4 | Conditioned input lanes toward the shift engine |
| core_dout | input | 4 | Data lines from the shift engine |
| pad_dout | output | 4 | Conditioned output lines toward the pads |

## Verification
A wrong tap select or a stale chain register shows on core_din as a bit stream shifted by a whole number of cycles from the pad stream, visible within four cycles of the pattern starting. A sampling register that loads on the wrong edge, or ignores the strobe, shows as a one-cycle shift or as repeated bits wherever the strobe was low. A settings register that loads while idle is low changes the delay or bypass behaviour on the very next cycle, and a wrong swap shows at once because the other lanes carry the complement pattern.

// File: rtl/spi_lt_pkg.sv
// Shared types for the SPI line timing stage.
// Assumes a 2-bit sampling mode field per input lane.
package spi_lt_pkg;

    typedef enum logic [1:0] {
        SMP_BYPASS = 2'd0,
        SMP_RISE   = 2'd1,
        SMP_FALL   = 2'd2,
        SMP_SCK    = 2'd3
    } smp_mode_e;

    localparam int MODE_W = 2;

endpackage

// File: rtl/spi_lt_cfg.sv
// Holds the taken line timing settings.
// Loads all settings on a rising edge while idle is high, keeps them
// otherwise. Assumes idle is already synchronous to clk.
module spi_lt_cfg #(
    parameter int LINES = 4,
    parameter int CNT_W = 2,
    parameter int MODE_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      idle,
    input  logic                      swap_in,
    input  logic [LINES*MODE_W-1:0]   mode_in,
    input  logic [LINES*CNT_W-1:0]    cnt_in,
    input  logic [LINES-1:0]          omode_in,
    output logic                      swap_q,
    output logic [LINES*MODE_W-1:0]   mode_q,
    output logic [LINES*CNT_W-1:0]    cnt_q,
    output logic [LINES-1:0]          omode_q
);

    // Capture settings only between transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swap_q  <= 1'b0;
            mode_q  <= '0;
            cnt_q   <= '0;
            omode_q <= '0;
        end else if (idle) begin
            swap_q  <= swap_in;
            mode_q  <= mode_in;
            cnt_q   <= cnt_in;
            omode_q <= omode_in;
        end
    end

    // R8: settings frozen while a transfer runs
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable({swap_q, mode_q, cnt_q, omode_q}));

    // R9: reset leaves every setting at its cleared value
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> ({swap_q, mode_q, cnt_q, omode_q} == '0));

endmodule

// File: rtl/spi_lt_in_lane.sv
// One input lane: picks the sampling source by mode, then delays it
// through a shift chain tapped by the count field.
// Assumes the serial-clock strobe is a one-cycle pulse in clk domain.
module spi_lt_in_lane
    import spi_lt_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_en,
    input  smp_mode_e        mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic             lane_in,
    output logic             lane_out
);

    localparam int DEPTH = 1 << CNT_W;

    logic             fall_q;
    logic             sck_q;
    logic             first_d;
    logic [DEPTH-1:0] chain_q;

    // Falling-edge sample of the pad line.
    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= lane_in;
    end

    // Serial-clock sample: loads only on strobed edges.
    always_ff @(posedge clk) begin
        if (!rst_n)      sck_q <= 1'b0;
        else if (sck_en) sck_q <= lane_in;
    end

    // Select the source that feeds the delay chain.
    always_comb begin
        case (mode)
            SMP_FALL: first_d = fall_q;
            SMP_SCK:  first_d = sck_q;
            default:  first_d = lane_in;
        endcase
    end

    // Delay chain; stage k holds the source k+1 edges old.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[DEPTH-2:0], first_d};
    end

    // Bypass or tap the chain at the programmed depth.
    always_comb begin
        if (mode == SMP_BYPASS) lane_out = lane_in;
        else                    lane_out = chain_q[cnt];
    end

    // R3: rising-edge sample with count 0 appears one edge later
    p_rise_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SMP_RISE && cnt == '0 && $past(mode == SMP_RISE))
        |-> lane_out == $past(lane_in));

    // R6: count 1 gives two edges of delay
    p_tap_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SMP_RISE && cnt == CNT_W'(1) && $past(mode == SMP_RISE)
         && $past(mode == SMP_RISE, 2))
        |-> lane_out == $past(lane_in, 2));

    // R4: falling-edge sample enters the chain on the next rising edge
    p_fall_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SMP_FALL && cnt == '0 && $past(mode == SMP_FALL))
        |-> lane_out == $past(fall_q));

    // R5: no new serial-clock sample without the strobe
    p_sck_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_en |=> $stable(sck_q));

endmodule

// File: rtl/spi_lt_out_lane.sv
// One output line: optional half-cycle retime onto the falling edge.
// Assumes the core changes its data on rising edges.
module spi_lt_out_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic retime,
    input  logic core_bit,
    output logic pad_bit
);

    logic neg_q;

    // Falling-edge copy of the core data.
    always_ff @(negedge clk) begin
        if (!rst_n) neg_q <= 1'b0;
        else        neg_q <= core_bit;
    end

    // Choose the direct or the retimed value.
    always_comb pad_bit = retime ? neg_q : core_bit;

    // R7: with retime on, the pad carries the previous falling-edge value
    p_retime_r7: assert property (@(negedge clk) disable iff (!rst_n)
        ($past(retime) && retime && $past(rst_n)) |-> pad_bit == $past(core_bit));

endmodule

// File: rtl/spi_line_timing.sv
// SPI data line timing stage: optional quad-line swap, per-lane input
// sampling and delay, per-line output retime.
// Assumes settings only change meaningfully while idle is high.
module spi_line_timing
    import spi_lt_pkg::*;
#(
    parameter int LINES = 4,
    parameter int CNT_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      idle,
    input  logic                      sck_en,
    input  logic                      cfg_swap,
    input  logic [LINES*MODE_W-1:0]   cfg_in_mode,
    input  logic [LINES*CNT_W-1:0]    cfg_in_cnt,
    input  logic [LINES-1:0]          cfg_out_mode,
    input  logic [LINES-1:0]          pad_din,
    output logic [LINES-1:0]          core_din,
    input  logic [LINES-1:0]          core_dout,
    output logic [LINES-1:0]          pad_dout
);

    logic                    swap_q;
    logic [LINES*MODE_W-1:0] mode_q;
    logic [LINES*CNT_W-1:0]  cnt_q;
    logic [LINES-1:0]        omode_q;
    logic [LINES-1:0]        lane_in;

    spi_lt_cfg #(
        .LINES  (LINES),
        .CNT_W  (CNT_W),
        .MODE_W (MODE_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle     (idle),
        .swap_in  (cfg_swap),
        .mode_in  (cfg_in_mode),
        .cnt_in   (cfg_in_cnt),
        .omode_in (cfg_out_mode),
        .swap_q   (swap_q),
        .mode_q   (mode_q),
        .cnt_q    (cnt_q),
        .omode_q  (omode_q)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_lane
        localparam int MIRROR = LINES - 1 - i;

        // Route the pad line, mirrored when swap is taken.
        always_comb lane_in[i] = swap_q ? pad_din[MIRROR] : pad_din[i];

        spi_lt_in_lane #(
            .CNT_W (CNT_W)
        ) u_in (
            .clk      (clk),
            .rst_n    (rst_n),
            .sck_en   (sck_en),
            .mode     (smp_mode_e'(mode_q[i*MODE_W +: MODE_W])),
            .cnt      (cnt_q[i*CNT_W +: CNT_W]),
            .lane_in  (lane_in[i]),
            .lane_out (core_din[i])
        );

        spi_lt_out_lane u_out (
            .clk      (clk),
            .rst_n    (rst_n),
            .retime   (omode_q[i]),
            .core_bit (core_dout[i]),
            .pad_bit  (pad_dout[i])
        );
    end

endmodule

// File: tb/spi_line_timing_tb.sv
module spi_line_timing_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idle = 1'b1;
    logic       sck_en = 1'b0;
    logic       cfg_swap = 1'b0;
    logic [7:0] cfg_in_mode = '0;
    logic [7:0] cfg_in_cnt = '0;
    logic [3:0] cfg_out_mode = '0;
    logic [3:0] pad_din = '0;
    logic [3:0] core_din;
    logic [3:0] core_dout = '0;
    logic [3:0] pad_dout;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    bit raw_h [64];
    bit en_h  [64];
    bit got_h [64];
    bit hold_h[64];

    spi_line_timing u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .idle         (idle),
        .sck_en       (sck_en),
        .cfg_swap     (cfg_swap),
        .cfg_in_mode  (cfg_in_mode),
        .cfg_in_cnt   (cfg_in_cnt),
        .cfg_out_mode (cfg_out_mode),
        .pad_din      (pad_din),
        .core_din     (core_din),
        .core_dout    (core_dout),
        .pad_dout     (pad_dout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Present settings for one lane, all others cleared.
    task automatic set_cfg(int lane, int mode, int cnt, bit sw);
        @(posedge clk);
        #1;
        cfg_in_mode = '0;
        cfg_in_cnt  = '0;
        cfg_in_mode[2*lane +: 2] = 2'(mode);
        cfg_in_cnt[2*lane +: 2]  = 2'(cnt);
        cfg_swap = sw;
    endtask

    // Drive a bit stream on the lane's pad and compare the core side
    // with the delay the expected mode and count call for.
    task automatic run_window(int lane, int emode, int ecnt, bit sw, string tag);
        int p;
        logic [7:0] l;
        int e;
        p = sw ? 3 - lane : lane;
        l = 8'hA5 ^ 8'(lane * 29 + ecnt * 7 + emode);
        for (int j = 0; j < 40; j++) begin
            raw_h[j] = (j < 8) ? 1'b0 : l[0];
            if (j >= 8) l = {l[6:0], l[7] ^ l[5] ^ l[4] ^ l[3]};
            en_h[j] = (j < 8) ? 1'b1 : (j % 3 == 0);
        end
        hold_h[0] = 1'b0;
        for (int j = 1; j < 40; j++)
            hold_h[j] = en_h[j-1] ? raw_h[j-1] : hold_h[j-1];
        for (int j = 0; j < 40; j++) begin
            @(posedge clk);
            #1 sck_en = en_h[j];
            #5 pad_din = raw_h[j] ? (4'b0001 << p) : ~(4'b0001 << p);
            #2 got_h[j] = core_din[lane];
        end
        for (int j = 8; j < 40; j++) begin
            case (emode)
                0: e = raw_h[j];
                1: e = raw_h[j-1-ecnt];
                2: e = raw_h[j-2-ecnt];
                default: e = hold_h[j-1-ecnt];
            endcase
            check(got_h[j] == e[0], tag, $sformatf("lane %0d mode %0d cnt %0d cycle %0d",
                  lane, emode, ecnt, j), int'(got_h[j]), e);
        end
    endtask

    // Output retime: at 3 time units after the rising edge a retimed line
    // still shows the previous core value, a direct line the new one.
    task automatic run_out(logic [3:0] om);
        logic [3:0] prev;
        logic [3:0] cur;
        @(posedge clk);
        #1 cfg_out_mode = om;
        prev = core_dout;
        for (int j = 0; j < 16; j++) begin
            @(posedge clk);
            #1 cur = 4'((j * 37) ^ 5);
            core_dout = cur;
            #2;
            if (j >= 2)
                for (int b = 0; b < 4; b++)
                    check(pad_dout[b] == (om[b] ? prev[b] : cur[b]), "R7",
                          $sformatf("early line %0d step %0d", b, j),
                          int'(pad_dout[b]), int'(om[b] ? prev[b] : cur[b]));
            #5;
            if (j >= 2)
                check(pad_dout == cur, "R7", $sformatf("late step %0d", j),
                      int'(pad_dout), int'(cur));
            prev = cur;
        end
    endtask

    task automatic t_reset_state();
        #2 pad_din = 4'b0110;
        core_dout = 4'b1001;
        #1;
        check(core_din == 4'b0110, "R9", "reset input bypass", int'(core_din), 6);
        check(pad_dout == 4'b1001, "R9", "reset output direct", int'(pad_dout), 9);
    endtask

    task automatic t_swap_bypass();
        set_cfg(0, 0, 0, 1'b1);
        @(posedge clk);
        #1 pad_din = 4'b0001;
        #1 check(core_din == 4'b1000, "R1", "swap 0001", int'(core_din), 8);
        pad_din = 4'b0100;
        #1 check(core_din == 4'b0010, "R1", "swap 0100", int'(core_din), 2);
        pad_din = 4'b1100;
        #1 check(core_din == 4'b0011, "R1", "swap 1100", int'(core_din), 3);
    endtask

    task automatic t_hold_cfg();
        set_cfg(0, 0, 0, 1'b0);
        run_window(0, 0, 0, 1'b0, "R8");
        idle = 1'b0;
        set_cfg(0, 1, 3, 1'b0);
        run_window(0, 0, 0, 1'b0, "R8");
        idle = 1'b1;
        run_window(0, 1, 3, 1'b0, "R8");
    endtask

    task automatic t_mid_reset();
        set_cfg(2, 1, 3, 1'b1);
        cfg_out_mode = 4'b1111;
        @(posedge clk);
        @(posedge clk);
        #1 idle = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        pad_din = 4'b1011;
        core_dout = 4'b0101;
        #2;
        check(core_din == 4'b1011, "R9", "after reset input bypass", int'(core_din), 11);
        check(pad_dout == 4'b0101, "R9", "after reset output direct", int'(pad_dout), 5);
        idle = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset_state();
        t_swap_bypass();
        set_cfg(1, 0, 3, 1'b0);
        run_window(1, 0, 3, 1'b0, "R2");
        set_cfg(0, 1, 0, 1'b0);
        run_window(0, 1, 0, 1'b0, "R3");
        set_cfg(1, 1, 1, 1'b0);
        run_window(1, 1, 1, 1'b0, "R6");
        set_cfg(2, 1, 2, 1'b0);
        run_window(2, 1, 2, 1'b0, "R6");
        set_cfg(3, 1, 3, 1'b0);
        run_window(3, 1, 3, 1'b0, "R6");
        set_cfg(1, 2, 1, 1'b0);
        run_window(1, 2, 1, 1'b0, "R4");
        set_cfg(2, 2, 0, 1'b0);
        run_window(2, 2, 0, 1'b0, "R4");
        set_cfg(2, 3, 2, 1'b0);
        run_window(2, 3, 2, 1'b0, "R5");
        set_cfg(0, 3, 0, 1'b0);
        run_window(0, 3, 0, 1'b0, "R5");
        set_cfg(0, 1, 1, 1'b1);
        run_window(0, 1, 1, 1'b1, "R1");
        set_cfg(3, 2, 3, 1'b1);
        run_window(3, 2, 3, 1'b1, "R1");
        t_hold_cfg();
        run_out(4'b0101);
        run_out(4'b1010);
        t_mid_reset();
        done = 1'b1;
        summary();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

endmodule